// File: doc/BRIEF.md
# One-Time-Programmable Word Memory with Mode Decode

This block is a synthesizable behavioural model of a word-wide, one-time-programmable read-only memory. Two active-low controls (chip select and output gate) and two digital flags decide the operating mode each cycle. One flag stands for the high programming supply. The other stands for the raised level on address line 9 that selects identification. The decoded modes are read, output off, standby, program, program-verify, program-inhibit and identification.

The data output is combinational from the address and the array. A separate drive-enable tells the surrounding logic when the bus would be actively driven. When the drive-enable is low the data lines are held at zero, so they stand in for a high-impedance bus. The array is erased to all ones at reset. A program operation can only clear bits. Exactly one write happens each time program mode is entered, on the first rising clock edge on which it is decoded. Identification returns one of two parameterized code words. The logical address is 18 bits wide, and only its low bits index a small parameterized array.

Top module: `otp_word_rom`

## Requirements
- R1: After reset every location is erased and reads as all ones (16'hFFFF).
- R2: With chip select low, output gate low and no identification condition, the block drives the word stored at the location selected by the low address bits, and the drive-enable is 1. This holds with or without the programming flag.
- R3: With output gate high and the programming flag low, the drive-enable is 0 and the data lines read 0, whatever chip select and the address are.
- R4: With chip select high and the programming flag low, the block is in standby: the drive-enable is 0 and the data lines read 0.
- R5: With the programming flag set, chip select low and output gate high, the block is in program mode. The addressed location becomes its old value ANDed with the input word, and the outputs are off.
- R6: Only one write occurs for each entry into program mode, on the first rising edge at which program mode is decoded. Later edges in the same entry write nothing, even if the address or the input word changes.
- R7: With the programming flag set, chip select high and output gate low, the block is in program-verify mode and drives the stored word at the address, with the drive-enable at 1.
- R8: With the programming flag set and both chip select and output gate high, the block is in program-inhibit mode: nothing is written and the outputs are off.
- R9: With chip select low, output gate low, the programming flag low, the identification flag set and all address bits above bit 0 zero, the block returns the manufacturer code when address bit 0 is 0 and the device code when it is 1.
- R10: With the identification flag set but any address bit above bit 0 set, the block performs a normal read.
- R11: Programming an already programmed word can only clear more bits. A bit that is 0 can never return to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; program writes are taken on its rising edge |
| rst_n | input | 1 | Active-low reset; erases the array |
| ce_n | input | 1 | Active-low chip select |
| oe_n | input | 1 | Active-low output gate |
| vpp_hi | input | 1 | Programming supply at high level |
| id_hi | input | 1 | Identification level present on address line 9 |
| addr | input | 18 | Word address |
| din | input | 16 | Word to program |
| dout | output | 16 | Read data; zero when not driven |
| dout_en | output | 1 | Data bus actively driven |

## Verification
Identification and a normal array read can both match the same cycle. At addresses 0 and 1, a read with the identification flag set could return either the array word or a code word. The bench first programs locations 0 and 1 with values unlike either code. It then reads those locations with the flag set and with it clear, and expects the code words in the first case and the programmed words in the second. It also expects a normal read at address 2 with the flag set. A second overlap is the program write with a change of address or data inside one program entry. The bench holds program mode over several edges with changing inputs and requires that only the first address and word were stored.

// File: rtl/otp_word_rom.sv
module otp_word_rom #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 18,
  parameter int DEPTH = 64,
  parameter logic [DATA_W-1:0] MFR_CODE = 16'h00C7,
  parameter logic [DATA_W-1:0] DEV_CODE = 16'hB29E
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              vpp_hi,
  input  logic              id_hi,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  typedef enum logic [2:0] {
    M_OFF, M_STBY, M_READ, M_PROG, M_VRFY, M_INHB, M_IDENT
  } mode_t;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [IDX_W-1:0]  idx;
  logic              prog_q;
  logic              wr_en;
  logic              id_match;
  mode_t             mode;

  assign idx      = addr[IDX_W-1:0];
  assign id_match = id_hi && (addr[ADDR_W-1:1] == '0);

  always_comb begin
    if (vpp_hi) begin
      case ({ce_n, oe_n})
        2'b01:   mode = M_PROG;
        2'b10:   mode = M_VRFY;
        2'b11:   mode = M_INHB;
        default: mode = M_READ;
      endcase
    end else if (oe_n) begin
      mode = M_OFF;
    end else if (ce_n) begin
      mode = M_STBY;
    end else if (id_match) begin
      mode = M_IDENT;
    end else begin
      mode = M_READ;
    end
  end

  assign wr_en   = (mode == M_PROG) && !prog_q;
  assign dout_en = (mode == M_READ) || (mode == M_VRFY) || (mode == M_IDENT);

  always_comb begin
    if (mode == M_IDENT)
      dout = addr[0] ? DEV_CODE : MFR_CODE;
    else if (dout_en)
      dout = mem[idx];
    else
      dout = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prog_q <= 1'b0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else begin
      prog_q <= (mode == M_PROG);
      if (wr_en) mem[idx] <= mem[idx] & din;
    end
  end

  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_n && !vpp_hi) |-> (!dout_en && dout == '0)); // R3
  AST_STBY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_n && !vpp_hi) |-> !dout_en); // R4
  AST_INHB_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (vpp_hi && ce_n && oe_n) |=> $stable(prog_q) || !prog_q); // R8
  AST_PROG_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (vpp_hi && !ce_n && oe_n) |-> !dout_en); // R5
  AST_VRFY_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (vpp_hi && ce_n && !oe_n) |-> dout_en); // R7
  AST_ONE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (vpp_hi && !ce_n && oe_n) |=> (vpp_hi && !ce_n && oe_n) |-> prog_q); // R6
  AST_ID_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (!vpp_hi && !ce_n && !oe_n && id_hi && addr[ADDR_W-1:1] == '0)
      |-> (dout == (addr[0] ? DEV_CODE : MFR_CODE))); // R9
  AST_BITS_ONLY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ((mem[$past(idx)] & ~$past(mem[idx])) == '0)); // R11
endmodule

// File: tb/sim_otp_word_rom.sv
module sim_otp_word_rom;
  localparam int DW = 16, AW = 18, DEPTH = 64;
  localparam logic [15:0] MFR = 16'h00C7, DEV = 16'hB29E;

  logic clk = 0, rst_n = 0, ce_n = 1, oe_n = 1, vpp_hi = 0, id_hi = 0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic dout_en;
  logic [DW-1:0] exp_mem [DEPTH];
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  otp_word_rom #(.DATA_W(DW), .ADDR_W(AW), .DEPTH(DEPTH),
                 .MFR_CODE(MFR), .DEV_CODE(DEV)) u0 (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .vpp_hi(vpp_hi),
    .id_hi(id_hi), .addr(addr), .din(din), .dout(dout), .dout_en(dout_en));

  task automatic chk(string r, logic [DW-1:0] got, logic [DW-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", r, got, exp);
    end
  endtask

  task automatic setp(logic c, logic o, logic v, logic i, logic [AW-1:0] a, logic [DW-1:0] d);
    @(negedge clk);
    ce_n = c; oe_n = o; vpp_hi = v; id_hi = i; addr = a; din = d;
    #1;
  endtask

  task automatic program_word(logic [AW-1:0] a, logic [DW-1:0] d);
    setp(1, 1, 1, 0, a, d);
    setp(0, 1, 1, 0, a, d);
    chk("R5 outputs off in program", {15'd0, dout_en}, 16'd0);
    setp(1, 1, 1, 0, a, 16'h0000);
    exp_mem[a[5:0]] = exp_mem[a[5:0]] & d;
  endtask

  task automatic t_reset();
    for (int i = 0; i < DEPTH; i++) exp_mem[i] = 16'hFFFF;
    setp(0, 0, 0, 0, 0, 0);
    chk("R1 erased word 0", dout, 16'hFFFF);
    setp(0, 0, 0, 0, 63, 0);
    chk("R1 erased word 63", dout, 16'hFFFF);
    chk("R2 drive-enable in read", {15'd0, dout_en}, 16'd1);
  endtask

  task automatic t_quiet_modes();
    setp(0, 1, 0, 0, 5, 0);
    chk("R3 off enable", {15'd0, dout_en}, 16'd0);
    chk("R3 off data", dout, 16'd0);
    setp(1, 1, 0, 1, 0, 0);
    chk("R3 off with standby", {15'd0, dout_en}, 16'd0);
    setp(1, 0, 0, 0, 5, 0);
    chk("R4 standby enable", {15'd0, dout_en}, 16'd0);
    chk("R4 standby data", dout, 16'd0);
  endtask

  task automatic t_program_verify();
    program_word(5, 16'h1234);
    setp(1, 0, 1, 0, 5, 0);
    chk("R7 verify enable", {15'd0, dout_en}, 16'd1);
    chk("R7 verify data", dout, exp_mem[5]);
    setp(0, 0, 0, 0, 5, 0);
    chk("R2 read programmed", dout, 16'h1234);
    setp(0, 0, 0, 0, 6, 0);
    chk("R2 neighbour untouched", dout, 16'hFFFF);
    setp(0, 0, 1, 0, 5, 0);
    chk("R2 read with supply high", dout, 16'h1234);
  endtask

  task automatic t_single_write();
    setp(1, 1, 1, 0, 10, 16'hF0F0);
    setp(0, 1, 1, 0, 10, 16'hF0F0);
    setp(0, 1, 1, 0, 10, 16'h0F0F);
    setp(0, 1, 1, 0, 11, 16'h0000);
    setp(1, 1, 1, 0, 11, 16'h0000);
    exp_mem[10] = 16'hF0F0;
    setp(1, 0, 1, 0, 10, 0);
    chk("R6 first word only", dout, exp_mem[10]);
    setp(1, 0, 1, 0, 11, 0);
    chk("R6 no write after address change", dout, 16'hFFFF);
  endtask

  task automatic t_inhibit();
    setp(1, 1, 1, 0, 20, 16'h0000);
    chk("R8 inhibit enable", {15'd0, dout_en}, 16'd0);
    chk("R8 inhibit data", dout, 16'd0);
    setp(1, 1, 1, 0, 20, 16'h0000);
    setp(1, 0, 1, 0, 20, 0);
    chk("R8 no write in inhibit", dout, 16'hFFFF);
  endtask

  task automatic t_ident();
    program_word(0, 16'h3C3C);
    program_word(1, 16'h4242);
    program_word(2, 16'h7E7E);
    setp(0, 0, 0, 1, 0, 0);
    chk("R9 manufacturer code", dout, MFR);
    chk("R9 drive-enable", {15'd0, dout_en}, 16'd1);
    setp(0, 0, 0, 1, 1, 0);
    chk("R9 device code", dout, DEV);
    setp(0, 0, 0, 0, 0, 0);
    chk("R2 word 0 without flag", dout, 16'h3C3C);
    setp(0, 0, 0, 0, 1, 0);
    chk("R2 word 1 without flag", dout, 16'h4242);
    setp(0, 0, 0, 1, 2, 0);
    chk("R10 flag with bit 1 set", dout, 16'h7E7E);
    setp(0, 0, 0, 1, 18'h20001, 0);
    chk("R10 flag with high bit set", dout, exp_mem[1]);
  endtask

  task automatic t_and();
    program_word(30, 16'hFF00);
    program_word(30, 16'h0FFF);
    setp(0, 0, 0, 0, 30, 0);
    chk("R11 bits only clear", dout, 16'h0F00);
    program_word(30, 16'hFFFF);
    setp(0, 0, 0, 0, 30, 0);
    chk("R11 zeros stay zero", dout, 16'h0F00);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_quiet_modes();
    t_program_verify();
    t_single_write();
    t_inhibit();
    t_ident();
    t_and();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule